// File: doc/BRIEF.md
# Register-File ALU with Skip Request

This block is the execute slice of a small 8-bit accumulator machine. It owns a register file of 2^ADDR_W bytes and a working register (W), and each cycle in which `opValid` is high it runs one already-decoded operation: decrement with skip on zero, increment, increment with skip on zero, OR of an 8-bit literal into W, or OR of W with a register. A destination bit sends the result either to W or back to the addressed register.

The register-file write port is presented combinationally during the execute cycle, together with a one-cycle skip request that tells the sequencer to squash the next fetched instruction. W and the zero flag are registered and show their new values one clock after the execute cycle. A write to the file is visible to an instruction issued in the very next cycle.

Top module: `rf_skip_alu`

## Requirements
- R1: After an active-low reset, `wValue` is 0x00, `zeroFlag` is 0 and every register of the file reads 0x00.
- R2: With `destSel` = 0 the result goes to W and the file is not written; with `destSel` = 1 the result is written to the register at `regAddr` and W keeps its value.
- R3: Opcode 1 (decrement-skip) computes register minus 1 modulo 256 (0x00 becomes 0xFF), raises `skipReq` in the execute cycle exactly when the result is 0x00, and leaves `zeroFlag` unchanged.
- R4: Opcode 2 (increment) computes register plus 1 modulo 256, sets `zeroFlag` to 1 when the result is 0x00 and to 0 otherwise, and never raises `skipReq`.
- R5: Opcode 3 (increment-skip) computes register plus 1 modulo 256, raises `skipReq` exactly when the result wraps to 0x00, and leaves `zeroFlag` unchanged.
- R6: Opcode 4 (OR-literal) writes W OR `literal` to W whatever `destSel` is, updates `zeroFlag` from the result and never writes the file.
- R7: Opcode 5 (OR-register) computes W OR the addressed register, routes it by `destSel` and updates `zeroFlag` from the result.
- R8: Opcodes 0, 6 and 7, and any cycle with `opValid` low, change no state, do not write the file and do not raise `skipReq`.
- R9: During the execute cycle `rfWrEn` is high only for a file-destined result, `rfWrAddr` equals `regAddr` and `rfWrData` carries the result; the written value is seen by an operation issued in the next cycle.
- R10: `skipReq` is high only in the execute cycle of a skipping operation whose result is 0x00, and is a single-cycle pulse per instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 3 | Decoded operation code (see R3 to R8) |
| regAddr | input | ADDR_W | Register-file address operand |
| destSel | input | 1 | 0: result to W, 1: result to the register |
| literal | input | DATA_W | Literal operand for OR-literal |
| rfWrEn | output | 1 | Register-file write strobe this cycle |
| rfWrAddr | output | ADDR_W | Register-file write address |
| rfWrData | output | DATA_W | Register-file write data |
| wValue | output | DATA_W | Current value of W |
| zeroFlag | output | 1 | Status zero flag |
| skipReq | output | 1 | Squash-next-instruction request |

## Verification
The bench builds the block with its default widths, eight data bits and seven address bits, so the full 128-entry file is swept at reset and both modulo-256 wrap points (0x00 to 0xFF and 0xFF to 0x00) are reached by short directed chains. Random traffic is confined to the lowest eight addresses so that write-then-read collisions between consecutive operations, including back-to-back skip cases, occur often.

// File: rtl/rfalu_pkg.sv
package rfalu_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_IDLE    = 3'd0,
    OP_DECSKIP = 3'd1,
    OP_INC     = 3'd2,
    OP_INCSKIP = 3'd3,
    OP_ORLIT   = 3'd4,
    OP_ORREG   = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } opKind_e;

  typedef enum logic [1:0] {
    SRC_DEC   = 2'd0,
    SRC_INC   = 2'd1,
    SRC_ORLIT = 2'd2,
    SRC_ORREG = 2'd3
  } aluSel_e;

  typedef struct packed {
    logic    active;
    aluSel_e aluSel;
    logic    toFile;
    logic    toW;
    logic    setZero;
    logic    skipOnZero;
  } ctrlStrobe_t;

endpackage

// File: rtl/rfalu_ctrl.sv
module rfalu_ctrl
  import rfalu_pkg::*;
(
  input  logic             opValid,
  input  logic [OPC_W-1:0] opCode,
  input  logic             destSel,
  output ctrlStrobe_t      strobe
);

  opKind_e opKind;
  logic    isKnown;
  logic    isOrLit;

  assign opKind = opKind_e'(opCode);

  always_comb begin
    isKnown = 1'b0;
    isOrLit = 1'b0;
    strobe  = '0;
    strobe.aluSel = SRC_ORREG;
    unique case (opKind)
      OP_DECSKIP: begin isKnown = 1'b1; strobe.aluSel = SRC_DEC; strobe.skipOnZero = 1'b1; end
      OP_INC:     begin isKnown = 1'b1; strobe.aluSel = SRC_INC; strobe.setZero = 1'b1; end
      OP_INCSKIP: begin isKnown = 1'b1; strobe.aluSel = SRC_INC; strobe.skipOnZero = 1'b1; end
      OP_ORLIT:   begin isKnown = 1'b1; isOrLit = 1'b1; strobe.aluSel = SRC_ORLIT; strobe.setZero = 1'b1; end
      OP_ORREG:   begin isKnown = 1'b1; strobe.aluSel = SRC_ORREG; strobe.setZero = 1'b1; end
      default:    begin isKnown = 1'b0; end
    endcase
    strobe.active = opValid & isKnown;
    if (!strobe.active) begin
      strobe.setZero    = 1'b0;
      strobe.skipOnZero = 1'b0;
    end
    strobe.toFile = strobe.active & destSel & ~isOrLit;
    strobe.toW    = strobe.active & (~destSel | isOrLit);
  end

endmodule

// File: rtl/rfalu_dpath.sv
module rfalu_dpath
  import rfalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] literal,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic [DATA_W-1:0] wValue,
  output logic              zeroFlag,
  output logic              skipReq
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] regFile [DEPTH];
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] wReg;
  logic              zReg;
  logic [DATA_W-1:0] aluResult;
  logic              resZero;

  assign rdData = regFile[regAddr];

  always_comb begin
    unique case (strobe.aluSel)
      SRC_DEC:   aluResult = rdData - ONE;
      SRC_INC:   aluResult = rdData + ONE;
      SRC_ORLIT: aluResult = wReg | literal;
      default:   aluResult = wReg | rdData;
    endcase
  end

  assign resZero  = (aluResult == '0);
  assign rfWrEn   = strobe.toFile;
  assign rfWrAddr = regAddr;
  assign rfWrData = aluResult;
  assign skipReq  = strobe.skipOnZero & resZero;
  assign wValue   = wReg;
  assign zeroFlag = zReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else if (rfWrEn) begin
      regFile[regAddr] <= aluResult;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wReg <= '0;
      zReg <= 1'b0;
    end else begin
      if (strobe.toW)     wReg <= aluResult;
      if (strobe.setZero) zReg <= resZero;
    end
  end

  // R2
  w_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.toW |=> wValue == $past(rfWrData));

  // R2
  file_keeps_w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rfWrEn |=> $stable(wValue));

  // R3
  skip_keeps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.skipOnZero |=> $stable(zeroFlag));

  // R4
  zero_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.setZero |=> zeroFlag == ($past(rfWrData) == '0));

  // R6
  orlit_no_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.active && strobe.aluSel == SRC_ORLIT) |-> !rfWrEn);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.active |=> $stable(wValue) && $stable(zeroFlag));

  // R10
  skip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skipReq |-> strobe.skipOnZero && strobe.active);

endmodule

// File: rtl/rf_skip_alu.sv
module rf_skip_alu
  import rfalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              destSel,
  input  logic [DATA_W-1:0] literal,
  output logic              rfWrEn,
  output logic [ADDR_W-1:0] rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic [DATA_W-1:0] wValue,
  output logic              zeroFlag,
  output logic              skipReq
);

  ctrlStrobe_t strobe;

  rfalu_ctrl ctrl_i (
    .opValid (opValid),
    .opCode  (opCode),
    .destSel (destSel),
    .strobe  (strobe)
  );

  rfalu_dpath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .regAddr  (regAddr),
    .literal  (literal),
    .rfWrEn   (rfWrEn),
    .rfWrAddr (rfWrAddr),
    .rfWrData (rfWrData),
    .wValue   (wValue),
    .zeroFlag (zeroFlag),
    .skipReq  (skipReq)
  );

endmodule

// File: tb/rf_skip_alu_tb_top.sv
`timescale 1ns/1ps
module rf_skip_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opValid = 1'b0;
  logic [2:0] opCode = 3'd0;
  logic [6:0] regAddr = 7'd0;
  logic       destSel = 1'b0;
  logic [7:0] literal = 8'd0;
  logic       rfWrEn;
  logic [6:0] rfWrAddr;
  logic [7:0] rfWrData;
  logic [7:0] wValue;
  logic       zeroFlag;
  logic       skipReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mRegs [128];
  int mW;
  int mZ;

  always #2 clk = ~clk;

  rf_skip_alu dut_i (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .regAddr(regAddr), .destSel(destSel), .literal(literal),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .wValue(wValue), .zeroFlag(zeroFlag), .skipReq(skipReq)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic doOp(bit v, int op, int a, bit d, int lit);
    int rv, res, expSkip, expWr, toW, zUpd;
    string tag;
    @(negedge clk);
    opValid = v; opCode = 3'(op); regAddr = 7'(a); destSel = d; literal = 8'(lit);
    #1;
    rv = mRegs[a]; res = 0; expSkip = 0; expWr = 0; toW = 0; zUpd = 0;
    case (op)
      1: tag = "R3";
      2: tag = "R4";
      3: tag = "R5";
      4: tag = "R6";
      5: tag = "R7";
      default: tag = "R8";
    endcase
    if (!v) tag = "R8";
    if (v && op >= 1 && op <= 5) begin
      case (op)
        1: res = (rv + 255) % 256;
        2: res = (rv + 1) % 256;
        3: res = (rv + 1) % 256;
        4: res = mW | lit;
        default: res = mW | rv;
      endcase
      if (op == 4) toW = 1;
      else if (d) expWr = 1;
      else toW = 1;
      if ((op == 1 || op == 3) && res == 0) expSkip = 1;
      if (op == 2 || op == 4 || op == 5) zUpd = 1;
    end
    check((op == 1 || op == 3) ? tag : "R10", "skipReq", skipReq, expSkip);
    check(tag, "rfWrEn", rfWrEn, expWr);
    if (expWr) begin
      check("R9", "rfWrAddr", rfWrAddr, a);
      check("R2", "rfWrData", rfWrData, res);
    end
    if (expWr) mRegs[a] = res;
    if (toW) mW = res;
    if (zUpd) mZ = (res == 0) ? 1 : 0;
    @(posedge clk);
    #1;
    check(tag, "wValue", wValue, mW);
    check(tag, "zeroFlag", zeroFlag, mZ);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mRegs[i] = 0;
    mW = 0; mZ = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values while still in reset
    check("R1", "wValue", wValue, 0);
    check("R1", "zeroFlag", zeroFlag, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: every register reads zero through OR-register into W
    for (int a = 0; a < 128; a++) begin
      doOp(1, 5, a, 0, 0);
      check("R1", "register read", wValue, 0);
    end
    // R3 R5 R4 wrap and skip corners on register 9
    doOp(1, 2, 9, 1, 0);      // R4 reg9 = 1
    doOp(1, 1, 9, 1, 0);      // R3 reg9 = 0, skip
    doOp(1, 1, 9, 1, 0);      // R3 reg9 = FF, no skip
    doOp(1, 3, 9, 1, 0);      // R5 wraps to 0, skip
    doOp(1, 1, 9, 1, 0);      // FF again
    doOp(1, 2, 9, 1, 0);      // R4 FF+1 = 0, zero flag set
    doOp(1, 2, 9, 0, 0);      // R4 to W, file unchanged (R2)
    doOp(1, 5, 9, 0, 0);      // R9 read back right after write
    // R6 OR-literal with destSel high must not touch the file
    doOp(1, 4, 9, 1, 8'h80);
    doOp(1, 5, 9, 0, 0);
    // R8 reserved codes and idle cycles
    doOp(1, 6, 3, 1, 8'hFF);
    doOp(1, 7, 3, 1, 8'hFF);
    doOp(1, 0, 3, 1, 8'hFF);
    doOp(0, 3, 3, 1, 8'hFF);
    doOp(1, 5, 3, 0, 0);
    // R7 R2 OR-register back to the file
    doOp(1, 5, 4, 1, 0);
    doOp(1, 3, 4, 0, 0);
    // random traffic on a narrow address window
    for (int n = 0; n < 3000; n++) begin
      int op, lit;
      bit v;
      op  = $urandom_range(0, 7);
      v   = ($urandom_range(0, 9) != 0);
      lit = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 255);
      doOp(v, op, $urandom_range(0, 7), 1'($urandom_range(0, 1)), lit);
    end
    done = 1;
    summary();
    $finish;
  end

endmodule